// File: doc/BRIEF.md
# Power-Good Startup Sequencer

This block governs the very first start of a clock generator's outputs. Out of reset it holds the global output enable low and ignores the frequency-select strap pins. It waits until the active-low power-good pin is seen low. The pin passes through a synchroniser and must read low on two consecutive synchronised samples. The block then counts a settling delay in reference-clock cycles and captures the strap pins once into a held register, raising a valid flag. After a second counted delay it raises the output enable.

The sequence runs once only. When the block reaches its run state, only a reset can take it out again. After that point the power-good pin and the strap pins have no further effect. Both delays are parameters in reference cycles. The defaults, 3580 and 14318 cycles of a 14.318 MHz reference, give about 0.25 ms and 1.0 ms.

Top module: `pwrseq_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `fs_valid` and `out_en` are 0 and `fs_latched` is 3'b000.
- R2: A low on `pwrgd_n` that lasts a single clock cycle does not start the sequence: `fs_valid` and `out_en` stay 0.
- R3: Number the rising clock edges from the first edge that samples `pwrgd_n` low as edge 1. `fs_valid` first reads 1 after edge SETTLE_CYCLES+5 and not before.
- R4: `fs_latched` equals the value `fs_pins` had at the edge where `fs_valid` rose, with bit 0 the first select input. It stays at that value while `fs_pins` later changes.
- R5: `out_en` first reads 1 after edge SETTLE_CYCLES+ENABLE_CYCLES+5, using the numbering of R3. `out_en` is never 1 while `fs_valid` is 0.
- R6: Once `out_en` is 1, toggling `pwrgd_n` or `fs_pins` changes none of the outputs until reset.
- R7: Once the sequence has started, `pwrgd_n` returning high neither aborts nor delays it.
- R8: A reset during or after the sequence clears all outputs, and a new sequence then runs with the timing of R3 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrgd_n | input | 1 | Power-good pin, active low, asynchronous |
| fs_pins | input | 3 | Frequency-select strap pins |
| fs_latched | output | 3 | Captured strap value |
| fs_valid | output | 1 | Strap value has been captured |
| out_en | output | 1 | Global output enable |

## Verification
The assertions check four things on every cycle. The enable never runs ahead of the strap capture. The captured value and valid flag never change once set. The run state and the enable are sticky. The controller leaves idle only on a qualified low. Exact edge counts of both delays, the glitch rejection, the strap value picked at the sampling edge and the indifference to the pin after the start can only be shown by the bench's timed scenarios.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int unsigned STRAP_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DELAY1 = 3'd1,
        ST_SAMPLE = 3'd2,
        ST_DELAY2 = 3'd3,
        ST_RUN    = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic               valid;
        logic [STRAP_W-1:0] bits;
    } strap_t;

    function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m + 1);
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic low_qual
);
    logic [STAGES-1:0] chain;
    logic              synced;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], pin_n};
            prev  <= synced;
        end
    end

    assign synced   = chain[STAGES-1];
    assign low_qual = !synced && !prev;

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 3580,
    parameter int unsigned ENABLE_CYCLES = 14318
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output seq_state_e state,
    output logic       sample,
    output logic       running
);
    localparam int unsigned CW = cnt_width(SETTLE_CYCLES, ENABLE_CYCLES);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);
    localparam logic [CW-1:0] ENABLE_LAST = CW'(ENABLE_CYCLES - 1);

    seq_state_e    state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_DELAY1;
                    cnt_nx   = '0;
                end
            end
            ST_DELAY1: begin
                if (cnt == SETTLE_LAST) begin
                    state_nx = ST_SAMPLE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_SAMPLE: begin
                state_nx = ST_DELAY2;
                cnt_nx   = '0;
            end
            ST_DELAY2: begin
                if (cnt == ENABLE_LAST) begin
                    state_nx = ST_RUN;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_RUN:  state_nx = ST_RUN;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    assign sample  = (state == ST_SAMPLE);
    assign running = (state == ST_RUN);

    // R2: idle is left only on a qualified low from the synchroniser
    a_r2_idle_wait: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |=> (state == ST_IDLE));

    // R6: the run state is left only by reset
    a_r6_run_sticky: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |=> (state == ST_RUN));

    // R7: once started, the sequence never falls back to idle
    a_r7_no_abort: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> (state != ST_IDLE));

endmodule

// File: rtl/pwrseq_strap.sv
module pwrseq_strap
    import pwrseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [STRAP_W-1:0] pins,
    output strap_t             held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (load) begin
            held.valid <= 1'b1;
            held.bits  <= pins;
        end
    end

    // R4: the straps are captured a single time per sequence
    a_r4_sample_once: assert property (@(posedge clk) disable iff (rst)
        load |-> !held.valid);

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 3580,
    parameter int unsigned ENABLE_CYCLES = 14318,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwrgd_n,
    input  logic [STRAP_W-1:0] fs_pins,
    output logic [STRAP_W-1:0] fs_latched,
    output logic               fs_valid,
    output logic               out_en
);
    logic       low_qual;
    logic       sample;
    logic       running;
    seq_state_e state;
    strap_t     held;

    pwrseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_n    (pwrgd_n),
        .low_qual (low_qual)
    );

    pwrseq_fsm #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .ENABLE_CYCLES (ENABLE_CYCLES)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (low_qual),
        .state   (state),
        .sample  (sample),
        .running (running)
    );

    pwrseq_strap u_strap (
        .clk  (clk),
        .rst  (rst),
        .load (sample),
        .pins (fs_pins),
        .held (held)
    );

    assign fs_latched = held.bits;
    assign fs_valid   = held.valid;
    assign out_en     = running;

    // R5: the enable never precedes the strap capture
    a_r5_enable_after_valid: assert property (@(posedge clk) disable iff (rst)
        out_en |-> fs_valid);

    // R4: the captured straps hold once valid
    a_r4_strap_hold: assert property (@(posedge clk) disable iff (rst)
        fs_valid |=> (fs_valid && $stable(fs_latched)));

    // R6: the enable stays up until reset
    a_r6_enable_sticky: assert property (@(posedge clk) disable iff (rst)
        out_en |=> out_en);

endmodule

// File: tb/pwrseq_top_test.sv
module pwrseq_top_test;
    localparam int S = 20;
    localparam int E = 40;

    typedef struct {
        string      kind;
        int         cyc;
        logic [2:0] val;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwrgd_n = 1'b1;
    logic [2:0] fs_pins = 3'b000;
    logic [2:0] fs_latched;
    logic       fs_valid;
    logic       out_en;

    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwrseq_top #(.SETTLE_CYCLES(S), .ENABLE_CYCLES(E), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .pwrgd_n(pwrgd_n), .fs_pins(fs_pins),
        .fs_latched(fs_latched), .fs_valid(fs_valid), .out_en(out_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // driver: pin goes low at this negedge; queue the events it must cause
    task automatic launch(input logic [2:0] strap);
        exp_t a, b;
        a.kind = "valid";  a.cyc = cyc + S + 5;     a.val = strap;
        b.kind = "enable"; b.cyc = cyc + S + E + 5; b.val = strap;
        sb.push_back(a);
        sb.push_back(b);
        pwrgd_n = 1'b0;
    endtask

    // monitor: pop an expected item whenever an output rises
    logic pv = 1'b0, pe = 1'b0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (fs_valid && !pv) begin
                if (sb.size() == 0) chk("R3 unexpected valid", 1, 0);
                else begin
                    exp_t x;
                    x = sb.pop_front();
                    chk("R3 valid kind", (x.kind == "valid"), 1);
                    chk("R3 valid cycle", cyc, x.cyc);
                    chk("R4 strap value", fs_latched, x.val);
                end
            end
            if (out_en && !pe) begin
                if (sb.size() == 0) chk("R5 unexpected enable", 1, 0);
                else begin
                    exp_t x;
                    x = sb.pop_front();
                    chk("R5 enable kind", (x.kind == "enable"), 1);
                    chk("R5 enable cycle", cyc, x.cyc);
                end
            end
        end
        pv = fs_valid;
        pe = out_en;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", fs_valid, 0);
        chk("R1 enable in reset", out_en, 0);
        chk("R1 strap in reset", fs_latched, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", fs_valid, 0);
        chk("R1 enable after reset", out_en, 0);

        // R2: single-cycle glitch low
        pwrgd_n = 1'b0;
        @(negedge clk);
        pwrgd_n = 1'b1;
        repeat (S + E + 10) @(negedge clk);
        chk("R2 glitch valid", fs_valid, 0);
        chk("R2 glitch enable", out_en, 0);

        // first sequence
        fs_pins = 3'b101;
        launch(3'b101);
        repeat (S + 6) @(negedge clk);
        fs_pins = 3'b010;
        repeat (E + 5) @(negedge clk);
        chk("R4 strap held after pin change", fs_latched, 3'b101);
        chk("R5 enable up", out_en, 1);

        // R6: toggles in run
        for (int i = 0; i < 4; i++) begin
            pwrgd_n = ~pwrgd_n;
            fs_pins = fs_pins + 3'd3;
            repeat (5) @(negedge clk);
            chk("R6 enable in run", out_en, 1);
            chk("R6 valid in run", fs_valid, 1);
            chk("R6 strap in run", fs_latched, 3'b101);
        end

        // R8: reset with the pin held low, then a second run
        rst = 1'b1;
        pwrgd_n = 1'b0;
        fs_pins = 3'b000;
        repeat (2) @(negedge clk);
        chk("R8 valid cleared", fs_valid, 0);
        chk("R8 enable cleared", out_en, 0);
        chk("R8 strap cleared", fs_latched, 0);
        rst = 1'b0;
        launch(3'b011);
        repeat (4) @(negedge clk);
        fs_pins = 3'b011;
        repeat (4) @(negedge clk);
        pwrgd_n = 1'b1;             // R7: pin bounces high during settling
        repeat (3) @(negedge clk);
        pwrgd_n = 1'b0;
        repeat (S + E + 5) @(negedge clk);
        chk("R8 second run enable", out_en, 1);
        chk("R7 second run strap", fs_latched, 3'b011);
        chk("R3 all events seen", sb.size(), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule